// File: doc/BRIEF.md
# Dual-Port Contention Busy Arbiter

This block guards a two-port shared memory against both ports working on one location at the same time. Each cycle it compares the left and right addresses. The comparison counts only while both port selects are active. When the two collide, one port keeps the location and the other is told it is busy. A busy port has its memory write held back. It also loses its two mailbox actions: raising an interrupt toward the other side, and clearing its own interrupt by reading its mailbox.

Several copies can be combined to build a wider word. One copy runs as master and drives its busy results outward. The others run as slaves. A slave takes those busy lines as inputs, does no arbitration of its own and delays its writes until the incoming busy has settled. Reset is asynchronous and active low. The block leaves reset in step with the clock, through a synchroniser whose depth is a parameter.

Top module: `dp_busy_arbiter`

## Requirements
- R1: A contention exists only while both port selects are high and both addresses are equal. With no contention in the current cycle or the one before, both busy outputs are low.
- R2: In master mode (`ms_sel`=1) the two busy outputs are never high together. During a contention exactly one of them is high.
- R3: When both ports reach the same location in the same cycle and neither held it the cycle before, the left port wins. `busy_r` goes high and `busy_l` stays low in that cycle.
- R4: A port counts as holding the location if it was selected at that same address in the previous cycle. When only one port holds it, that port wins, the newcomer sees busy, and the winner stays fixed for as long as the contention lasts.
- R5: A port that lost a contention still sees busy in the first cycle after the contention ends. Its busy falls in the cycle after that.
- R6: A port's write-allowed output equals select AND write request. It is forced low while that port sees busy.
- R7: A port that sees busy cannot raise the interrupt toward the other port. Its interrupt-set output is low even when it requests one.
- R8: A port that sees busy cannot clear its own mailbox interrupt. Its interrupt-clear output is low even when it reads its mailbox.
- R9: In master mode the busy outputs come only from the block's own arbitration. The external busy inputs have no effect on any output.
- R10: In slave mode (`ms_sel`=0) each busy output copies the matching busy input. The block's own arbitration has no effect.
- R11: In slave mode a port's write-allowed output stays low while its busy input is high, and also in the first cycle after that input falls.
- R12: While `rst_n` is low, and for SYNC_STAGES clock edges after it rises, both busy outputs stay low even if a contention is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_sel | input | 1 | 1 = master (own arbitration), 0 = slave (busy taken from inputs) |
| l_ce | input | 1 | Left port select |
| l_addr | input | ADDR_W | Left port address |
| l_we | input | 1 | Left port write request |
| l_mbx_wr | input | 1 | Left port request to raise the interrupt toward the right |
| l_mbx_rd | input | 1 | Left port mailbox read, clears its own interrupt |
| r_ce | input | 1 | Right port select |
| r_addr | input | ADDR_W | Right port address |
| r_we | input | 1 | Right port write request |
| r_mbx_wr | input | 1 | Right port request to raise the interrupt toward the left |
| r_mbx_rd | input | 1 | Right port mailbox read, clears its own interrupt |
| busy_in_l | input | 1 | Left busy from a master (slave mode) |
| busy_in_r | input | 1 | Right busy from a master (slave mode) |
| busy_l | output | 1 | Busy seen by the left port |
| busy_r | output | 1 | Busy seen by the right port |
| l_we_ok | output | 1 | Left write allowed to reach the memory |
| r_we_ok | output | 1 | Right write allowed to reach the memory |
| l_int_set_ok | output | 1 | Left interrupt raise allowed |
| r_int_set_ok | output | 1 | Right interrupt raise allowed |
| l_int_clr_ok | output | 1 | Left mailbox-read clear allowed |
| r_int_clr_ok | output | 1 | Right mailbox-read clear allowed |

## Verification
The bench builds the block with ADDR_W=4 and SYNC_STAGES=2. The narrow address lets a handful of directed values produce both matching and mismatching pairs, including pairs that differ in a single bit. The two-stage synchroniser puts the whole reset release window of R12 inside three observed cycles. Together these settings bring the tie, the incumbent wins on each side, the one-cycle release tail and the slave settle cycle within a few cycles each.

// File: rtl/dpb_pkg.sv
package dpb_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  localparam int PORTS = 2;
  localparam int P_LEFT = 0;
  localparam int P_RIGHT = 1;
endpackage

// File: rtl/dpb_rst_sync.sv
module dpb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/dpb_match.sv
// Address comparison and "already holding" detection for each port.
module dpb_match #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_ce,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_ce,
  input  logic [ADDR_W-1:0] r_addr,
  output logic              hit,
  output logic              l_held,
  output logic              r_held
);
  logic              l_ce_q, r_ce_q;
  logic [ADDR_W-1:0] l_addr_q, r_addr_q;
  logic [ADDR_W-1:0] l_addr_d, r_addr_d;

  assign hit    = l_ce && r_ce && (l_addr == r_addr);
  assign l_held = l_ce && l_ce_q && (l_addr_q == l_addr);
  assign r_held = r_ce && r_ce_q && (r_addr_q == r_addr);

  // address history only loads while its port is selected
  always_comb begin
    l_addr_d = l_addr_q;
    r_addr_d = r_addr_q;
    if (l_ce) l_addr_d = l_addr;
    if (r_ce) r_addr_d = r_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_ce_q   <= 1'b0;
      r_ce_q   <= 1'b0;
      l_addr_q <= '0;
      r_addr_q <= '0;
    end else begin
      l_ce_q   <= l_ce;
      r_ce_q   <= r_ce;
      l_addr_q <= l_addr_d;
      r_addr_q <= r_addr_d;
    end
  end
endmodule

// File: rtl/dpb_owner.sv
// Decides which port owns a contended location and derives arbitrated busy.
module dpb_owner
  import dpb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic l_held,
  input  logic r_held,
  output logic busy_l_arb,
  output logic busy_r_arb
);
  owner_e own_d, own_q;

  always_comb begin
    own_d = OWN_NONE;
    if (hit) begin
      if (own_q != OWN_NONE)       own_d = own_q;
      else if (r_held && !l_held)  own_d = OWN_RIGHT;
      else                         own_d = OWN_LEFT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) own_q <= OWN_NONE;
    else        own_q <= own_d;
  end

  // loser stays busy one cycle past the end of contention
  always_comb begin
    busy_l_arb = 1'b0;
    busy_r_arb = 1'b0;
    if (rst_n) begin
      busy_l_arb = (own_d == OWN_RIGHT) ||
                   ((own_q == OWN_RIGHT) && (own_d != OWN_LEFT));
      busy_r_arb = (own_d == OWN_LEFT) ||
                   ((own_q == OWN_LEFT) && (own_d != OWN_RIGHT));
    end
  end
endmodule

// File: rtl/dpb_gate.sv
// Per-port busy selection and gating of write and mailbox actions.
module dpb_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_sel,
  input  logic ce,
  input  logic we,
  input  logic mbx_wr,
  input  logic mbx_rd,
  input  logic busy_arb,
  input  logic busy_ext,
  output logic busy_seen,
  output logic we_ok,
  output logic int_set_ok,
  output logic int_clr_ok
);
  logic ext_q, ext_d;
  logic settled;

  assign ext_d = ms_sel ? 1'b0 : busy_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_q <= 1'b0;
    else        ext_q <= ext_d;
  end

  always_comb begin
    busy_seen  = ms_sel ? busy_arb : busy_ext;
    settled    = ms_sel ? 1'b1 : !ext_q;
    we_ok      = ce && we && !busy_seen && settled;
    int_set_ok = mbx_wr && !busy_seen;
    int_clr_ok = mbx_rd && !busy_seen;
  end
endmodule

// File: rtl/dp_busy_arbiter.sv
module dp_busy_arbiter
  import dpb_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ms_sel,
  input  logic              l_ce,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_we,
  input  logic              l_mbx_wr,
  input  logic              l_mbx_rd,
  input  logic              r_ce,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_we,
  input  logic              r_mbx_wr,
  input  logic              r_mbx_rd,
  input  logic              busy_in_l,
  input  logic              busy_in_r,
  output logic              busy_l,
  output logic              busy_r,
  output logic              l_we_ok,
  output logic              r_we_ok,
  output logic              l_int_set_ok,
  output logic              r_int_set_ok,
  output logic              l_int_clr_ok,
  output logic              r_int_clr_ok
);
  logic rst_s;
  logic hit, l_held, r_held;
  logic busy_l_arb, busy_r_arb;

  logic [PORTS-1:0] ce_v, we_v, mw_v, mr_v, arb_v, ext_v;
  logic [PORTS-1:0] seen_v, weok_v, set_v, clr_v;

  dpb_rst_sync #(.STAGES(SYNC_STAGES)) i_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_s)
  );

  dpb_match #(.ADDR_W(ADDR_W)) i_match (
    .clk(clk), .rst_n(rst_s),
    .l_ce(l_ce), .l_addr(l_addr), .r_ce(r_ce), .r_addr(r_addr),
    .hit(hit), .l_held(l_held), .r_held(r_held)
  );

  dpb_owner i_owner (
    .clk(clk), .rst_n(rst_s),
    .hit(hit), .l_held(l_held), .r_held(r_held),
    .busy_l_arb(busy_l_arb), .busy_r_arb(busy_r_arb)
  );

  assign ce_v  = {r_ce, l_ce};
  assign we_v  = {r_we, l_we};
  assign mw_v  = {r_mbx_wr, l_mbx_wr};
  assign mr_v  = {r_mbx_rd, l_mbx_rd};
  assign arb_v = {busy_r_arb, busy_l_arb};
  assign ext_v = {busy_in_r, busy_in_l};

  generate
    for (genvar p = 0; p < PORTS; p++) begin : g_port
      dpb_gate i_gate (
        .clk(clk), .rst_n(rst_s), .ms_sel(ms_sel),
        .ce(ce_v[p]), .we(we_v[p]), .mbx_wr(mw_v[p]), .mbx_rd(mr_v[p]),
        .busy_arb(arb_v[p]), .busy_ext(ext_v[p]),
        .busy_seen(seen_v[p]), .we_ok(weok_v[p]),
        .int_set_ok(set_v[p]), .int_clr_ok(clr_v[p])
      );
    end
  endgenerate

  assign busy_l       = seen_v[P_LEFT];
  assign busy_r       = seen_v[P_RIGHT];
  assign l_we_ok      = weok_v[P_LEFT];
  assign r_we_ok      = weok_v[P_RIGHT];
  assign l_int_set_ok = set_v[P_LEFT];
  assign r_int_set_ok = set_v[P_RIGHT];
  assign l_int_clr_ok = clr_v[P_LEFT];
  assign r_int_clr_ok = clr_v[P_RIGHT];
endmodule

// File: rtl/dpb_checker.sv
module dpb_checker #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ms_sel,
  input logic              l_ce,
  input logic [ADDR_W-1:0] l_addr,
  input logic              r_ce,
  input logic [ADDR_W-1:0] r_addr,
  input logic              busy_in_l,
  input logic              busy_in_r,
  input logic              busy_l,
  input logic              busy_r,
  input logic              l_we_ok,
  input logic              r_we_ok,
  input logic              l_int_set_ok,
  input logic              r_int_set_ok,
  input logic              l_int_clr_ok,
  input logic              r_int_clr_ok
);
  logic cont;
  assign cont = l_ce && r_ce && (l_addr == r_addr);

  assert_never_both_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ms_sel |-> !(busy_l && busy_r));

  assert_quiet_without_contention_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ms_sel && $past(ms_sel) && !cont && !$past(cont)) |-> (!busy_l && !busy_r));

  assert_busy_blocks_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_l |-> !l_we_ok) and (busy_r |-> !r_we_ok));

  assert_busy_blocks_int_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_l |-> !l_int_set_ok) and (busy_r |-> !r_int_set_ok));

  assert_busy_blocks_int_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_l |-> !l_int_clr_ok) and (busy_r |-> !r_int_clr_ok));

  assert_slave_mirrors_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ms_sel |-> ((busy_l == busy_in_l) && (busy_r == busy_in_r)));

  assert_slave_settle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ms_sel && $past(!ms_sel) && $past(busy_in_l)) |-> !l_we_ok);

  assert_release_tail_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ms_sel && $past(ms_sel) && $past(cont) && !cont && $past(busy_l)) |-> busy_l);
endmodule

bind dp_busy_arbiter dpb_checker #(.ADDR_W(ADDR_W)) i_dpb_checker (
  .clk(clk), .rst_n(rst_n), .ms_sel(ms_sel),
  .l_ce(l_ce), .l_addr(l_addr), .r_ce(r_ce), .r_addr(r_addr),
  .busy_in_l(busy_in_l), .busy_in_r(busy_in_r),
  .busy_l(busy_l), .busy_r(busy_r),
  .l_we_ok(l_we_ok), .r_we_ok(r_we_ok),
  .l_int_set_ok(l_int_set_ok), .r_int_set_ok(r_int_set_ok),
  .l_int_clr_ok(l_int_clr_ok), .r_int_clr_ok(r_int_clr_ok)
);

// File: tb/test_dp_busy_arbiter.sv
module test_dp_busy_arbiter;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic ms_sel;
  logic l_ce, l_we, l_mbx_wr, l_mbx_rd;
  logic r_ce, r_we, r_mbx_wr, r_mbx_rd;
  logic [AW-1:0] l_addr, r_addr;
  logic busy_in_l, busy_in_r;
  logic busy_l, busy_r, l_we_ok, r_we_ok;
  logic l_int_set_ok, r_int_set_ok, l_int_clr_ok, r_int_clr_ok;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  dp_busy_arbiter #(.ADDR_W(AW), .SYNC_STAGES(2)) i_dp_busy_arbiter (
    .clk(clk), .rst_n(rst_n), .ms_sel(ms_sel),
    .l_ce(l_ce), .l_addr(l_addr), .l_we(l_we), .l_mbx_wr(l_mbx_wr), .l_mbx_rd(l_mbx_rd),
    .r_ce(r_ce), .r_addr(r_addr), .r_we(r_we), .r_mbx_wr(r_mbx_wr), .r_mbx_rd(r_mbx_rd),
    .busy_in_l(busy_in_l), .busy_in_r(busy_in_r),
    .busy_l(busy_l), .busy_r(busy_r), .l_we_ok(l_we_ok), .r_we_ok(r_we_ok),
    .l_int_set_ok(l_int_set_ok), .r_int_set_ok(r_int_set_ok),
    .l_int_clr_ok(l_int_clr_ok), .r_int_clr_ok(r_int_clr_ok)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // advance to the next falling edge; inputs change there, checks follow 1 ns later
  task automatic step();
    @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      step();
      l_ce = 0; r_ce = 0; l_we = 0; r_we = 0;
      l_mbx_wr = 0; l_mbx_rd = 0; r_mbx_wr = 0; r_mbx_rd = 0;
      busy_in_l = 0; busy_in_r = 0;
    end
  endtask

  task automatic t_reset();
    rst_n = 0; ms_sel = 1;
    l_ce = 1; r_ce = 1; l_addr = 4'd3; r_addr = 4'd3;
    l_we = 0; r_we = 0; l_mbx_wr = 0; l_mbx_rd = 0; r_mbx_wr = 0; r_mbx_rd = 0;
    busy_in_l = 0; busy_in_r = 0;
    step(); step(); settle();
    chk("R12", "busy_r in reset", busy_r, 1'b0);
    chk("R12", "busy_l in reset", busy_l, 1'b0);
    step(); rst_n = 1; settle();
    chk("R12", "busy_r before edge 1", busy_r, 1'b0);
    step(); settle();
    chk("R12", "busy_r before edge 2", busy_r, 1'b0);
    step(); settle();
    chk("R12", "busy_r after sync release", busy_r, 1'b1);
    idle(3);
  endtask

  task automatic t_no_match();
    step(); l_ce = 1; r_ce = 1; l_addr = 4'd5; r_addr = 4'd4; l_we = 1; r_we = 1; settle();
    chk("R1", "busy_l diff addr", busy_l, 1'b0);
    chk("R1", "busy_r diff addr", busy_r, 1'b0);
    chk("R6", "l_we_ok no contention", l_we_ok, 1'b1);
    step(); r_addr = 4'd5; r_ce = 0; settle();
    chk("R1", "busy_l right deselected", busy_l, 1'b0);
    chk("R1", "busy_r right deselected", busy_r, 1'b0);
    chk("R6", "r_we_ok without select", r_we_ok, 1'b0);
    idle(2);
  endtask

  task automatic t_tie();
    step(); l_ce = 1; r_ce = 1; l_addr = 4'd9; r_addr = 4'd9;
    r_we = 1; r_mbx_wr = 1; r_mbx_rd = 1; l_we = 1; settle();
    chk("R3", "busy_r on tie", busy_r, 1'b1);
    chk("R3", "busy_l on tie", busy_l, 1'b0);
    chk("R6", "r_we_ok while busy", r_we_ok, 1'b0);
    chk("R6", "l_we_ok as winner", l_we_ok, 1'b1);
    chk("R7", "r_int_set_ok while busy", r_int_set_ok, 1'b0);
    chk("R8", "r_int_clr_ok while busy", r_int_clr_ok, 1'b0);
    idle(3);
  endtask

  task automatic t_incumbent_right();
    step(); r_ce = 1; r_addr = 4'd6; settle();
    chk("R4", "busy_r alone", busy_r, 1'b0);
    step(); l_ce = 1; l_addr = 4'd6; l_we = 1; l_mbx_wr = 1; l_mbx_rd = 1; settle();
    chk("R4", "busy_l newcomer", busy_l, 1'b1);
    chk("R4", "busy_r incumbent", busy_r, 1'b0);
    chk("R7", "l_int_set_ok while busy", l_int_set_ok, 1'b0);
    chk("R8", "l_int_clr_ok while busy", l_int_clr_ok, 1'b0);
    chk("R6", "l_we_ok while busy", l_we_ok, 1'b0);
    step(); settle();
    chk("R4", "busy_l stays during contention", busy_l, 1'b1);
    step(); r_ce = 0; settle();
    chk("R5", "busy_l tail cycle", busy_l, 1'b1);
    chk("R7", "l_int_set_ok tail cycle", l_int_set_ok, 1'b0);
    step(); settle();
    chk("R5", "busy_l released", busy_l, 1'b0);
    chk("R7", "l_int_set_ok after release", l_int_set_ok, 1'b1);
    chk("R8", "l_int_clr_ok after release", l_int_clr_ok, 1'b1);
    idle(3);
  endtask

  task automatic t_incumbent_left();
    step(); l_ce = 1; l_addr = 4'd12; settle();
    step(); r_ce = 1; r_addr = 4'd12; settle();
    chk("R4", "busy_r newcomer", busy_r, 1'b1);
    chk("R2", "busy_l with left incumbent", busy_l, 1'b0);
    step(); l_ce = 0; settle();
    chk("R5", "busy_r tail cycle", busy_r, 1'b1);
    step(); settle();
    chk("R5", "busy_r released", busy_r, 1'b0);
    idle(3);
  endtask

  task automatic t_master_ext();
    step(); ms_sel = 1; busy_in_l = 1; busy_in_r = 1; l_ce = 1; l_addr = 4'd1; l_we = 1;
    r_ce = 1; r_addr = 4'd2; settle();
    chk("R9", "busy_l ignores input", busy_l, 1'b0);
    chk("R9", "l_we_ok ignores input", l_we_ok, 1'b1);
    chk("R9", "busy_r ignores input", busy_r, 1'b0);
    idle(3);
  endtask

  task automatic t_slave();
    step(); ms_sel = 0; l_ce = 1; r_ce = 1; l_addr = 4'd8; r_addr = 4'd8; l_we = 1; r_we = 1; settle();
    chk("R10", "busy_r ignores own contention", busy_r, 1'b0);
    chk("R10", "r_we_ok in slave", r_we_ok, 1'b1);
    step(); busy_in_l = 1; settle();
    chk("R10", "busy_l mirrors input", busy_l, 1'b1);
    chk("R11", "l_we_ok while input high", l_we_ok, 1'b0);
    step(); busy_in_l = 0; settle();
    chk("R10", "busy_l follows fall", busy_l, 1'b0);
    chk("R11", "l_we_ok settle cycle", l_we_ok, 1'b0);
    step(); settle();
    chk("R11", "l_we_ok after settle", l_we_ok, 1'b1);
    idle(3);
    step(); ms_sel = 1;
    idle(2);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_no_match();
    t_tie();
    t_incumbent_right();
    t_incumbent_left();
    t_master_ext();
    t_slave();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule